// File: doc/BRIEF.md
# Per-Bank DRAM Command Issuer

This block is the last stage of a staged memory scheduler. Requests that earlier stages have already grouped and ordered arrive one per cycle, each naming a bank, a row and a read or write. The block queues each request in a small FIFO for its bank. It then turns the request at the head of each bank queue into simplified DRAM commands: row open, row close, column read and column write. It never looks past a head, so requests to the same bank keep their order.

Each cycle the block checks every bank head against that bank's row-buffer state and against a few timing counters. These cover open-to-column delay, close-to-open delay, minimum open time, a rolling limit on row opens, and a write-to-read turnaround. Among the banks that can issue, one is picked in round-robin order, so at most one command leaves per cycle. A count of the requests held in all queues is exported, together with a flag that says whether the count is low enough for an upstream bypass path to be used.

Top module: `dram_cmd_issuer`

## Requirements
- R1: After reset no command is valid, the in-flight count is 0, the bypass flag is 1 and requests to every bank are accepted.
- R2: Command codes on `cmd_op_o` are 0 = row open, 1 = row close, 2 = read, 3 = write. A head request whose row is open leaves as a read or write, according to `req_write_i` (1 = write), carrying its row, and is then removed from its queue.
- R3: A head request to a bank with no open row first produces a row open for its row. The column command follows exactly `T_RCD` cycles later when nothing else competes.
- R4: A head request to a bank holding a different open row first produces a row close. The close comes no sooner than `T_RAS` cycles after that bank's row open. The next row open to that bank comes no sooner than `T_RP` cycles after the close. Without competition both gaps are exact.
- R5: Column commands to one bank leave in the order in which the requests to that bank were accepted.
- R6: When several banks can issue in the same cycle, the grant goes to the first such bank at or after the bank following the last granted bank, wrapping from the highest bank index to 0.
- R7: No `T_FAW`-cycle window contains more than four row opens.
- R8: A read leaves no sooner than `T_WTR` cycles after the most recent write, to any bank.
- R9: `inflight_o` equals the number of accepted requests minus the read and write commands issued so far. `bypass_ok_o` is 1 exactly when `inflight_o` is below `BYPASS_LIMIT` (16).
- R10: `req_ready_o` is 0 while the queue of the bank named on `req_bank_i` holds `FIFO_DEPTH` requests, and a request offered then is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered this cycle |
| req_bank_i | input | 3 | Target bank |
| req_row_i | input | 8 | Target row |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_ready_o | output | 1 | Target bank queue has room |
| cmd_valid_o | output | 1 | Command on the command outputs |
| cmd_op_o | output | 2 | Command code (see R2) |
| cmd_bank_o | output | 3 | Command bank |
| cmd_row_o | output | 8 | Command row |
| inflight_o | output | 6 | Requests held across all bank queues |
| bypass_ok_o | output | 1 | In-flight count below the bypass limit |

## Verification
The round-robin order is the hardest behaviour to observe. Requests enter one per cycle, so under normal traffic two banks are rarely eligible in the same cycle, and a simple fixed-priority picker would often give the same order. The bench therefore issues a write to bank 4. It then queues reads to banks 6 and 1 while the write-to-read turnaround holds both reads back. Both become eligible in the same cycle, and the pointer then sits just past bank 4, so the grant must go to bank 6 before bank 1. A separate sequence from reset sends row opens to all eight banks, so that the rolling row-open limit holds up the fifth one.

// File: rtl/dcmd_pkg.sv
package dcmd_pkg;
  typedef enum logic [1:0] {
    OP_ACT = 2'd0,
    OP_PRE = 2'd1,
    OP_RD  = 2'd2,
    OP_WR  = 2'd3
  } cmd_op_e;
endpackage

// File: rtl/cmd_fifo.sv
module cmd_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 9,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign dout_o  = mem_q[rd_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= din_i;
        wr_q        <= nxt(wr_q);
      end
      if (pop_i) rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end
endmodule

// File: rtl/bank_tracker.sv
module bank_tracker #(
  parameter int ROW_W = 8,
  parameter int TW    = 4,
  parameter int T_RCD = 2,
  parameter int T_RP  = 3,
  parameter int T_RAS = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             col_ok_o,
  output logic             act_ok_o,
  output logic             pre_ok_o
);
  logic [TW-1:0] rcd_q, rp_q, ras_q;

  assign col_ok_o = (rcd_q == '0);
  assign act_ok_o = (rp_q == '0);
  assign pre_ok_o = (ras_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o <= 1'b0;
      row_o  <= '0;
      rcd_q  <= '0;
      rp_q   <= '0;
      ras_q  <= '0;
    end else begin
      rcd_q <= act_i ? TW'(T_RCD - 1) : (rcd_q != '0) ? rcd_q - 1'b1 : rcd_q;
      ras_q <= act_i ? TW'(T_RAS - 1) : (ras_q != '0) ? ras_q - 1'b1 : ras_q;
      rp_q  <= pre_i ? TW'(T_RP - 1)  : (rp_q  != '0) ? rp_q  - 1'b1 : rp_q;
      if (act_i) begin
        open_o <= 1'b1;
        row_o  <= row_i;
      end else if (pre_i) begin
        open_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          adv_i,
  output logic          gnt_valid_o,
  output logic [IW-1:0] gnt_idx_o
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    // walk downward so the smallest offset from the pointer wins
    for (int i = N - 1; i >= 0; i--) begin
      int j;
      j = (int'(ptr_q) + i) % N;
      if (req_i[j]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = IW'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (adv_i && gnt_valid_o)
      ptr_q <= (gnt_idx_o == IW'(N - 1)) ? '0 : gnt_idx_o + 1'b1;
  end
endmodule

// File: rtl/dram_cmd_issuer.sv
module dram_cmd_issuer
  import dcmd_pkg::*;
#(
  parameter int NUM_BANKS    = 8,
  parameter int FIFO_DEPTH   = 4,
  parameter int ROW_W        = 8,
  parameter int T_RCD        = 2,
  parameter int T_RP         = 3,
  parameter int T_RAS        = 5,
  parameter int T_FAW        = 10,
  parameter int T_WTR        = 6,
  parameter int ACT_WIN      = 4,
  parameter int BYPASS_LIMIT = 16,
  localparam int BW   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int NW   = $clog2(NUM_BANKS * FIFO_DEPTH + 1),
  localparam int TMAX = (T_RCD > T_RP) ? ((T_RCD > T_RAS) ? T_RCD : T_RAS)
                                       : ((T_RP > T_RAS) ? T_RP : T_RAS),
  localparam int TW   = $clog2(TMAX + 1),
  localparam int FW   = $clog2(T_FAW + 1),
  localparam int WW   = $clog2(T_WTR + 1),
  localparam int EW   = ROW_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [BW-1:0]    req_bank_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic             req_write_i,
  output logic             req_ready_o,
  output logic             cmd_valid_o,
  output logic [1:0]       cmd_op_o,
  output logic [BW-1:0]    cmd_bank_o,
  output logic [ROW_W-1:0] cmd_row_o,
  output logic [NW-1:0]    inflight_o,
  output logic             bypass_ok_o
);
  logic [NUM_BANKS-1:0] full, empty, push, pop, act_go, pre_go;
  logic [NUM_BANKS-1:0] is_open, col_ok, act_ok, pre_ok, hit, elig;
  logic [ROW_W-1:0]     head_row [NUM_BANKS];
  logic [NUM_BANKS-1:0] head_wr;
  logic [ROW_W-1:0]     open_row [NUM_BANKS];

  logic          gnt_v;
  logic [BW-1:0] gnt_i;
  logic [WW-1:0] wtr_q;
  logic [FW-1:0] faw_q [ACT_WIN];
  logic          faw_ok, any_act, any_wr, any_col;
  logic [$clog2(ACT_WIN)-1:0] faw_slot;

  assign req_ready_o = !full[req_bank_i];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [EW-1:0] dout;
    logic          sel;

    assign push[b] = req_valid_i && (req_bank_i == BW'(b)) && !full[b];
    assign head_row[b] = dout[ROW_W-1:0];
    assign head_wr[b]  = dout[ROW_W];

    cmd_fifo #(.DEPTH(FIFO_DEPTH), .W(EW)) u_fifo (
      .clk_i, .rst_ni,
      .push_i (push[b]),
      .din_i  ({req_write_i, req_row_i}),
      .pop_i  (pop[b]),
      .dout_o (dout),
      .empty_o(empty[b]),
      .full_o (full[b])
    );

    bank_tracker #(.ROW_W(ROW_W), .TW(TW), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)) u_trk (
      .clk_i, .rst_ni,
      .act_i   (act_go[b]),
      .pre_i   (pre_go[b]),
      .row_i   (head_row[b]),
      .open_o  (is_open[b]),
      .row_o   (open_row[b]),
      .col_ok_o(col_ok[b]),
      .act_ok_o(act_ok[b]),
      .pre_ok_o(pre_ok[b])
    );

    assign hit[b]  = is_open[b] && (open_row[b] == head_row[b]);
    assign elig[b] = !empty[b] && (
        (hit[b] && col_ok[b] && (head_wr[b] || wtr_q == '0)) ||
        (is_open[b] && !hit[b] && pre_ok[b]) ||
        (!is_open[b] && act_ok[b] && faw_ok));

    assign sel       = gnt_v && (gnt_i == BW'(b));
    assign pop[b]    = sel && hit[b];
    assign act_go[b] = sel && !is_open[b];
    assign pre_go[b] = sel && is_open[b] && !hit[b];
  end

  rr_pick #(.N(NUM_BANKS)) u_rr (
    .clk_i, .rst_ni,
    .req_i      (elig),
    .adv_i      (1'b1),
    .gnt_valid_o(gnt_v),
    .gnt_idx_o  (gnt_i)
  );

  assign any_act = |act_go;
  assign any_col = |pop;
  assign any_wr  = any_col && head_wr[gnt_i];

  // row-open history: one countdown per recent open
  always_comb begin
    faw_ok   = 1'b0;
    faw_slot = '0;
    for (int s = ACT_WIN - 1; s >= 0; s--) begin
      if (faw_q[s] == '0) begin
        faw_ok   = 1'b1;
        faw_slot = $bits(faw_slot)'(s);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < ACT_WIN; s++) faw_q[s] <= '0;
      wtr_q <= '0;
    end else begin
      for (int s = 0; s < ACT_WIN; s++) begin
        if (any_act && faw_slot == $bits(faw_slot)'(s)) faw_q[s] <= FW'(T_FAW - 1);
        else if (faw_q[s] != '0)                        faw_q[s] <= faw_q[s] - 1'b1;
      end
      wtr_q <= any_wr ? WW'(T_WTR - 1) : (wtr_q != '0) ? wtr_q - 1'b1 : wtr_q;
    end
  end

  cmd_op_e op_d;
  always_comb begin
    if (hit[gnt_i])          op_d = head_wr[gnt_i] ? OP_WR : OP_RD;
    else if (is_open[gnt_i]) op_d = OP_PRE;
    else                     op_d = OP_ACT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o <= 1'b0;
      cmd_op_o    <= '0;
      cmd_bank_o  <= '0;
      cmd_row_o   <= '0;
      inflight_o  <= '0;
    end else begin
      cmd_valid_o <= gnt_v;
      cmd_op_o    <= op_d;
      cmd_bank_o  <= gnt_i;
      cmd_row_o   <= head_row[gnt_i];
      inflight_o  <= inflight_o + NW'(|push) - NW'(any_col);
    end
  end

  assign bypass_ok_o = (inflight_o < NW'(BYPASS_LIMIT));
endmodule

// File: rtl/dram_cmd_issuer_chk.sv
module dram_cmd_issuer_chk #(
  parameter int NUM_BANKS    = 8,
  parameter int FIFO_DEPTH   = 4,
  parameter int ROW_W        = 8,
  parameter int T_RCD        = 2,
  parameter int T_RP         = 3,
  parameter int T_RAS        = 5,
  parameter int T_FAW        = 10,
  parameter int T_WTR        = 6,
  parameter int ACT_WIN      = 4,
  parameter int BYPASS_LIMIT = 16,
  localparam int BW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int NW  = $clog2(NUM_BANKS * FIFO_DEPTH + 1),
  localparam int CAP = T_FAW + T_RAS + T_RP + T_RCD + T_WTR,
  localparam int CW  = $clog2(CAP + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [BW-1:0]    req_bank_i,
  input logic [ROW_W-1:0] req_row_i,
  input logic             req_write_i,
  input logic             req_ready_o,
  input logic             cmd_valid_o,
  input logic [1:0]       cmd_op_o,
  input logic [BW-1:0]    cmd_bank_o,
  input logic [ROW_W-1:0] cmd_row_o,
  input logic [NW-1:0]    inflight_o,
  input logic             bypass_ok_o
);
  logic is_act, is_pre, is_col, is_rd, is_wr;
  assign is_act = cmd_valid_o && cmd_op_o == 2'd0;
  assign is_pre = cmd_valid_o && cmd_op_o == 2'd1;
  assign is_rd  = cmd_valid_o && cmd_op_o == 2'd2;
  assign is_wr  = cmd_valid_o && cmd_op_o == 2'd3;
  assign is_col = is_rd || is_wr;

  function automatic logic [CW-1:0] inc(input logic [CW-1:0] v);
    return (v == CW'(CAP)) ? v : v + 1'b1;
  endfunction

  logic [CW-1:0] since_wr;
  logic [CW-1:0] act_age [ACT_WIN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_wr <= CW'(CAP);
      for (int i = 0; i < ACT_WIN; i++) act_age[i] <= CW'(CAP);
    end else begin
      since_wr <= is_wr ? CW'(1) : inc(since_wr);
      if (is_act) begin
        act_age[0] <= CW'(1);
        for (int i = 1; i < ACT_WIN; i++) act_age[i] <= inc(act_age[i-1]);
      end else begin
        for (int i = 0; i < ACT_WIN; i++) act_age[i] <= inc(act_age[i]);
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bk
    logic [CW-1:0] since_act, since_pre;
    logic          here;
    assign here = cmd_bank_o == BW'(b);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        since_act <= CW'(CAP);
        since_pre <= CW'(CAP);
      end else begin
        since_act <= (is_act && here) ? CW'(1) : inc(since_act);
        since_pre <= (is_pre && here) ? CW'(1) : inc(since_pre);
      end
    end

    AST_RCD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_col && here) |-> since_act >= CW'(T_RCD)); // R3
    AST_RAS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_pre && here) |-> since_act >= CW'(T_RAS)); // R4
    AST_RP_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_act && here) |-> since_pre >= CW'(T_RP)); // R4
  end

  AST_WTR_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rd |-> since_wr >= CW'(T_WTR)); // R8
  AST_FAW_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> act_age[ACT_WIN-1] >= CW'(T_FAW)); // R7
  AST_INFLIGHT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (inflight_o - $past(inflight_o) <= NW'(1)) ||
             ($past(inflight_o) - inflight_o <= NW'(1))); // R9
  AST_INFLIGHT_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_o <= NW'(NUM_BANKS * FIFO_DEPTH)); // R10
endmodule

bind dram_cmd_issuer dram_cmd_issuer_chk #(
  .NUM_BANKS(NUM_BANKS), .FIFO_DEPTH(FIFO_DEPTH), .ROW_W(ROW_W),
  .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_FAW(T_FAW),
  .T_WTR(T_WTR), .ACT_WIN(ACT_WIN), .BYPASS_LIMIT(BYPASS_LIMIT)
) u_chk (.*);

// File: tb/tb_dram_cmd_issuer.sv
module tb_dram_cmd_issuer;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8, DEPTH = 4, ROW_W = 8;
  localparam int T_RCD = 2, T_RP = 3, T_RAS = 5, T_FAW = 10, T_WTR = 6, LIMIT = 16;
  localparam int LOGN = 1024;

  logic clk_i = 0, rst_ni = 0;
  logic req_valid_i = 0, req_write_i = 0;
  logic [2:0] req_bank_i = '0;
  logic [ROW_W-1:0] req_row_i = '0;
  logic req_ready_o, cmd_valid_o, bypass_ok_o;
  logic [1:0] cmd_op_o;
  logic [2:0] cmd_bank_o;
  logic [ROW_W-1:0] cmd_row_o;
  logic [5:0] inflight_o;

  dram_cmd_issuer #(.NUM_BANKS(NB), .FIFO_DEPTH(DEPTH), .ROW_W(ROW_W),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_FAW(T_FAW), .T_WTR(T_WTR),
    .BYPASS_LIMIT(LIMIT)) dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0, nlog = 0;
  int lop [LOGN], lbank [LOGN], lrow [LOGN], lcyc [LOGN];
  int acc = 0, cols = 0, mism = 0, byp_bad = 0, saw_high = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: log commands and track the in-flight model
  always @(negedge clk_i) begin
    cyc++;
    if (!rst_ni) begin
      acc = 0; cols = 0;
    end else begin
      if (cmd_valid_o && nlog < LOGN) begin
        lop[nlog] = cmd_op_o; lbank[nlog] = cmd_bank_o;
        lrow[nlog] = cmd_row_o; lcyc[nlog] = cyc; nlog++;
      end
      if (cmd_valid_o && cmd_op_o >= 2) cols++;
      if (int'(inflight_o) != acc - cols) mism++;
      if (bypass_ok_o != (inflight_o < LIMIT)) byp_bad++;
      if (inflight_o >= LIMIT) saw_high = 1;
      if (req_valid_i && req_ready_o) acc++;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic do_reset();
    rst_ni = 0; req_valid_i = 0;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1;
  endtask

  // caller sits just after a rising edge; returns just after the accepting edge
  task automatic push(input int b, input int row, input bit wr);
    bit rdy;
    req_valid_i = 1; req_bank_i = 3'(b); req_row_i = ROW_W'(row); req_write_i = wr;
    forever begin
      #1 rdy = req_ready_o;
      @(posedge clk_i); #1;
      if (rdy) break;
    end
    req_valid_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  function automatic int find(input int from, input int op, input int b);
    for (int i = from; i < nlog; i++)
      if (lop[i] == op && lbank[i] == b) return i;
    return -1;
  endfunction

  task automatic t_reset();
    #1;
    check(cmd_valid_o == 0, "R1 cmd_valid", cmd_valid_o, 0);
    check(inflight_o == 0, "R1 inflight", inflight_o, 0);
    check(bypass_ok_o == 1, "R1 bypass", bypass_ok_o, 1);
    check(req_ready_o == 1, "R1 ready", req_ready_o, 1);
  endtask

  task automatic t_miss_read();
    int s, a, r;
    s = nlog;
    push(0, 5, 0); idle(15);
    a = find(s, 0, 0); r = find(s, 2, 0);
    check(a >= 0 && lrow[a] == 5, "R3 open row", a >= 0 ? lrow[a] : -1, 5);
    check(r > a && lrow[r] == 5, "R2 read row", r >= 0 ? lrow[r] : -1, 5);
    check(a >= 0 && r > a && lcyc[r] - lcyc[a] == T_RCD, "R3 open-to-read gap",
          (a >= 0 && r >= 0) ? lcyc[r] - lcyc[a] : -1, T_RCD);
  endtask

  task automatic t_hit_write();
    int s, w;
    s = nlog;
    push(0, 5, 1); idle(15);
    w = find(s, 3, 0);
    check(w == s && nlog == s + 1, "R2 write on open row only", nlog - s, 1);
  endtask

  task automatic t_conflict();
    int s, a1, p, a2, r;
    s = nlog;
    push(2, 1, 0); push(2, 3, 0); idle(30);
    a1 = find(s, 0, 2); p = find(s, 1, 2);
    a2 = (p >= 0) ? find(p, 0, 2) : -1;
    r  = (a2 >= 0) ? find(a2, 2, 2) : -1;
    check(a1 >= 0 && p > a1 && lcyc[p] - lcyc[a1] == T_RAS, "R4 open-to-close gap",
          (p >= 0 && a1 >= 0) ? lcyc[p] - lcyc[a1] : -1, T_RAS);
    check(a2 > p && lcyc[a2] - lcyc[p] == T_RP, "R4 close-to-open gap",
          a2 >= 0 ? lcyc[a2] - lcyc[p] : -1, T_RP);
    check(r > 0 && lrow[r] == 3, "R4 read of new row", r >= 0 ? lrow[r] : -1, 3);
  endtask

  task automatic t_order();
    int s, k;
    int erow [3] = '{1, 2, 1};
    int eop  [3] = '{2, 3, 2};
    s = nlog; k = 0;
    push(3, 1, 0); push(3, 2, 1); push(3, 1, 0); idle(60);
    for (int i = s; i < nlog; i++)
      if (lbank[i] == 3 && lop[i] >= 2) begin
        if (k < 3) check(lrow[i] == erow[k] && lop[i] == eop[k], "R5 column order row",
                         lrow[i], erow[k]);
        k++;
      end
    check(k == 3, "R5 column count", k, 3);
  endtask

  task automatic t_rr_wtr();
    int s, w, r1, r2;
    push(1, 7, 0); push(6, 7, 0); push(4, 7, 0); idle(30);
    s = nlog;
    push(4, 7, 1);
    while (find(s, 3, 4) < 0) idle(1);
    push(6, 7, 0); push(1, 7, 0); idle(30);
    w = find(s, 3, 4);
    r1 = -1; r2 = -1;
    for (int i = w; i < nlog; i++)
      if (lop[i] == 2) begin
        if (r1 < 0) r1 = i; else if (r2 < 0) r2 = i;
      end
    check(r1 > 0 && lbank[r1] == 6, "R6 first grant bank", r1 > 0 ? lbank[r1] : -1, 6);
    check(r2 > 0 && lbank[r2] == 1, "R6 second grant bank", r2 > 0 ? lbank[r2] : -1, 1);
    check(r1 > 0 && lcyc[r1] - lcyc[w] == T_WTR, "R8 write-to-read gap",
          r1 > 0 ? lcyc[r1] - lcyc[w] : -1, T_WTR);
  endtask

  task automatic t_faw();
    int s, n, ok, ord;
    int at [8];
    do_reset();
    s = nlog; n = 0; ok = 1; ord = 1;
    for (int b = 0; b < NB; b++) push(b, 2, 0);
    idle(50);
    for (int i = s; i < nlog; i++)
      if (lop[i] == 0) begin
        if (n < 8) begin
          at[n] = lcyc[i];
          if (lbank[i] != n) ord = 0;
        end
        n++;
      end
    check(n == 8, "R7 open count", n, 8);
    for (int i = 0; i + 4 < 8 && i + 4 < n; i++)
      if (at[i+4] - at[i] < T_FAW) ok = 0;
    check(ok == 1, "R7 five opens span window", ok, 1);
    check(n == 8 && at[4] - at[0] == T_FAW, "R7 fifth open released",
          n == 8 ? at[4] - at[0] : -1, T_FAW);
    check(ord == 1, "R6 open order", ord, 1);
  endtask

  task automatic t_full();
    do_reset();
    for (int k = 1; k <= 5; k++) push(5, k, 0);
    req_valid_i = 1; req_bank_i = 3'd5; req_row_i = 8'd9; req_write_i = 0;
    #1;
    check(req_ready_o == 0, "R10 full bank not ready", req_ready_o, 0);
    check(inflight_o == 4, "R9 inflight at full", inflight_o, 4);
    req_bank_i = 3'd0; #1;
    check(req_ready_o == 1, "R10 other bank ready", req_ready_o, 1);
    req_valid_i = 0;
    idle(80);
  endtask

  task automatic t_load();
    do_reset();
    mism = 0; byp_bad = 0; saw_high = 0;
    for (int k = 0; k < 4; k++)
      for (int b = 0; b < NB; b++) push(b, 10 + k, k[0]);
    idle(400);
    check(saw_high == 1, "R9 count reached limit", saw_high, 1);
    check(mism == 0, "R9 inflight tracking", mism, 0);
    check(byp_bad == 0, "R9 bypass flag", byp_bad, 0);
    check(inflight_o == 0, "R9 drained", inflight_o, 0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_miss_read();
    t_hit_write();
    t_conflict();
    t_order();
    t_rr_wtr();
    t_faw();
    t_full();
    t_load();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule